// File: doc/BRIEF.md
# First-Order Pulse-Density Modulator

The block turns a multi-bit unsigned level into a one-bit pulse-density stream. Level and output share one scale that runs from zero to a full-scale value `FS`, counted in integer ticks. An output bit of 1 stands for `FS` and a bit of 0 stands for zero. On each clock where the step enable is high, the block does four things in order. It takes the bit it produced on the previous step and turns it back into `FS` or 0. It subtracts that value from the level. It adds the difference to a signed running integrator. It then registers a new output bit, which is 1 only when the updated integrator lies strictly above `FS/2`.

A low step enable freezes both the integrator and the output bit. This lets the modulator advance at any rate below the system clock. A level above `FS` is treated as `FS`. The integrator is wide enough to cover every value it can reach, so it never wraps. Averaged over many steps, the fraction of 1 bits equals the level divided by `FS`.

Top module: `pdm_modulator`

## Requirements
- R1: While `rst` is high at a rising clock edge, the output bit and the integrator are cleared to zero. The first step after reset therefore starts from an empty integrator and a previous bit of 0.
- R2: On an edge where `step_en` is low and `rst` is low, the output bit and the integrator keep their values, whatever the level input does.
- R3: With `FS` = 10 and a level of 4, the eight output bits after reset are 0,1,0,1,0,0,1,0. The integrator values on those steps are 4, 8, 2, 6, 0, 4, 8, 2.
- R4: On an enabled step, the new integrator value is the old value plus the level, minus `FS` if the current output bit is 1. The new output bit is 1 exactly when that new value is greater than `FS/2` (integer division).
- R5: Over 10·`FS` enabled steps starting from reset, the count of 1 bits differs from 10 times the level by at most 2.
- R6: A level code greater than `FS` acts exactly as a level of `FS`.
- R7: A level of 0 keeps the output at 0 on every step. A level of `FS` gives a 1 from the first step onward.
- R8: The integrator always stays within −`FS/2` to 3·`FS/2`, so it never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advances the modulator by one step when high |
| level | input | LW = $clog2(FS+1) | Unsigned input level, 0 to FS |
| pdm_out | output | 1 | Registered pulse-density bit |

## Verification
The assertions are checked on every edge. They cover clearing on reset and freezing of state while the enable is low. They also cover the exact integrator update on every enabled step, including when an over-range level is saturated to `FS`, and they keep the integrator inside its bound. Some behaviours show only over a stretch of steps, so only the bench's scenarios can show them. These are the exact bit pattern for a level of 4, the long-run density of 1 bits, and the steady outputs at the two extreme levels. The bench checks every level code, including the over-range codes, against its own arithmetic model of the loop, with a mix of enabled and idle edges.

// File: rtl/pdm_modulator.sv
module pdm_modulator #(
  parameter int FS = 10,
  parameter int LW = $clog2(FS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic [LW-1:0] level,
  output logic          pdm_out
);
  localparam int HALF = FS / 2;
  localparam int AW   = $clog2(3 * FS + 1) + 2;

  logic        [LW-1:0] lvl_sat;
  logic signed [AW-1:0] acc, acc_nxt, fb;

  assign lvl_sat = (int'(level) > FS) ? LW'(FS) : level;
  assign fb      = pdm_out ? AW'(FS) : '0;
  assign acc_nxt = acc + signed'(AW'(lvl_sat)) - fb;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      pdm_out <= 1'b0;
    end else if (step_en) begin
      acc     <= acc_nxt;
      pdm_out <= acc_nxt > signed'(AW'(HALF));
    end
  end
endmodule

// File: rtl/pdm_modulator_chk.sv
module pdm_modulator_chk #(
  parameter int FS = 10,
  parameter int LW = $clog2(FS + 1),
  parameter int AW = $clog2(3 * FS + 1) + 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 step_en,
  input logic [LW-1:0]        level,
  input logic                 pdm_out,
  input logic signed [AW-1:0] acc
);
  localparam int HALF = FS / 2;

  function automatic logic signed [AW-1:0] sat(input logic [LW-1:0] l);
    return (int'(l) > FS) ? AW'(FS) : AW'(l);
  endfunction

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pdm_out && acc == '0));

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(pdm_out) && $stable(acc)));

  // R4
  a_r4_update: assert property (@(posedge clk) disable iff (rst)
    step_en |=> acc == $past(acc) + sat($past(level)) - ($past(pdm_out) ? AW'(FS) : AW'(0)));

  // R6
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (step_en && int'(level) > FS) |=> acc == $past(acc) + AW'(FS) - ($past(pdm_out) ? AW'(FS) : AW'(0)));

  // R8
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (acc >= -signed'(AW'(HALF)) && acc <= signed'(AW'(3 * FS / 2))));
endmodule

bind pdm_modulator pdm_modulator_chk #(.FS(FS), .LW(LW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .level(level), .pdm_out(pdm_out), .acc(acc)
);

// File: tb/test_pdm_modulator.sv
`timescale 1ns/1ps
module test_pdm_modulator;
  localparam int FS = 10;
  localparam int LW = $clog2(FS + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_en = 1'b0;
  logic [LW-1:0] level = '0;
  logic          pdm_out;

  always #5 clk = ~clk;

  pdm_modulator #(.FS(FS)) i_pdm_modulator (
    .clk(clk), .rst(rst), .step_en(step_en), .level(level), .pdm_out(pdm_out)
  );

  int checks = 0, fails = 0;
  int m_acc = 0;
  bit m_q = 1'b0;
  bit done = 1'b0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; step_en = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0; m_acc = 0; m_q = 1'b0;
  endtask

  task automatic step(bit en, int lvl, string req);
    int s;
    level = LW'(lvl); step_en = en;
    @(posedge clk); @(negedge clk);
    if (en) begin
      s = (lvl > FS) ? FS : lvl;
      m_acc = m_acc + s - (m_q ? FS : 0);
      m_q = (m_acc > FS / 2);
    end
    check(req, int'(pdm_out), int'(m_q));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seq[8] = '{0, 1, 0, 1, 0, 0, 1, 0};
    bit last;
    int ones, exp;

    do_reset();
    check("R1 reset output", int'(pdm_out), 0);

    // R3 reference sequence
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 4, "R3 model");
      check("R3 sequence", int'(pdm_out), seq[i]);
    end

    // R1 mid-run reset restarts the sequence
    for (int i = 0; i < 5; i++) step(1'b1, 7, "R4 pre-reset");
    do_reset();
    check("R1 after mid reset", int'(pdm_out), 0);
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 4, "R1 model");
      check("R1 sequence restart", int'(pdm_out), seq[i]);
    end

    // R2 hold with changing level
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 3, "R4 before hold");
      last = pdm_out;
      for (int j = 0; j < 4; j++) begin
        step(1'b0, (j * 5 + k) % 16, "R2 model");
        check("R2 hold", int'(pdm_out), int'(last));
      end
    end

    // R4 / R6 sweep of all codes with mixed enables
    for (int lvl = 0; lvl < (1 << LW); lvl++) begin
      do_reset();
      for (int i = 0; i < 40; i++) step((i % 3) != 2, lvl, lvl > FS ? "R6 sweep" : "R4 sweep");
    end

    // R5 density
    for (int lvl = 0; lvl <= FS; lvl++) begin
      do_reset();
      ones = 0;
      for (int i = 0; i < 10 * FS; i++) begin
        step(1'b1, lvl, "R5 model");
        ones += int'(pdm_out);
      end
      exp = lvl * 10;
      check("R5 density", (ones - exp <= 2 && exp - ones <= 2) ? exp : ones, exp);
    end

    // R7 extremes, R6 over-range
    do_reset();
    for (int i = 0; i < 30; i++) begin
      step(1'b1, 0, "R7 model");
      check("R7 zero level", int'(pdm_out), 0);
    end
    do_reset();
    for (int i = 0; i < 30; i++) begin
      step(1'b1, FS, "R7 model");
      check("R7 full level", int'(pdm_out), 1);
    end
    do_reset();
    for (int i = 0; i < 30; i++) begin
      step(1'b1, (1 << LW) - 1, "R6 model");
      check("R6 over-range", int'(pdm_out), 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule